// File: doc/BRIEF.md
# LIN Frame Control Sequencer with Self-Checking One-Hot State

This block paces one LIN frame through its fields: break, sync, protected identifier, a run of data bytes and the checksum. It then waits for a slave response when one is expected, and finishes with a completion cycle. A serialiser outside the block pulses a byte-finished strobe each time the field it is sending or receiving is complete. The sequencer answers with one enable line per phase, so the serialiser knows which field to work on.

The eight phases are held in eight flip-flops, and exactly one of them is set in normal operation. A population check runs on the state register every cycle. Any vector with no bit set, or with more than one bit set, is caught. On the next clock the machine goes back to idle and a sticky error flag is raised for the host to see. A test input can flip any single state flip-flop for one clock, so the checker can be exercised in the field or in a bench.

The host programs the data length and the response direction and then pulses a start request. Both settings are captured when the frame starts and are held for the rest of that frame.

Top module: `lin_frame_seq`

## Requirements
- R1: A synchronous active-high reset puts `state_en` at 8'h01 (idle only), with `frame_done` low and `err_flag` low after the clock edge.
- R2: In idle the machine stays put until `start_req` is high at a clock edge, and then shows 8'h02 (break) after that edge. `byte_done` has no effect in idle.
- R3: The break (bit 1), sync (bit 2) and identifier (bit 3) phases each hold while `byte_done` is low. Each one moves to the next bit on the edge where `byte_done` is high, and the identifier moves on to data (bit 4).
- R4: `data_len` is the byte count minus one, so 0 to 7 stand for 1 to 8 bytes. It is captured on the edge that accepts `start_req`. Data (bit 4) stays set until that many `byte_done` pulses have arrived, and the last of them moves the machine to checksum (bit 5). A change of `data_len` during a frame has no effect on that frame.
- R5: `resp_dir` is captured when the frame starts. A `byte_done` in checksum moves to response wait (bit 6) when it is 1, and to done (bit 7) when it is 0.
- R6: Response wait holds while `byte_done` is low and moves to done on a `byte_done` pulse.
- R7: Done lasts exactly one cycle. `frame_done` is high in that cycle only, and the next edge returns to idle.
- R8: Without fault injection, `state_en` always has exactly one bit set.
- R9: When `inj_en` is high at an edge, the bit chosen by `inj_sel` (0 to 7) of the state loaded at that edge is inverted, for that one cycle only.
- R10: A state vector with zero or several set bits is replaced by idle (8'h01) at the next edge, and `err_flag` is high after that same edge.
- R11: `err_flag` stays high until `err_clr` is high at an edge with no illegal state present. A new detection wins over a clear in the same cycle.
- R12: `start_req` is ignored in every phase other than idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Begin a frame (taken in idle only) |
| byte_done | input | 1 | Current field finished |
| data_len | input | $clog2(MAX_BYTES) | Data byte count minus one |
| resp_dir | input | 1 | 1: a slave response follows the checksum |
| err_clr | input | 1 | Clear the sticky error flag |
| inj_en | input | 1 | Test only: invert one state bit this edge |
| inj_sel | input | 3 | Test only: index of the bit to invert |
| state_en | output | 8 | Phase enables: idle, break, sync, identifier, data, checksum, response wait, done (bit 0 to 7) |
| frame_done | output | 1 | High during the single done cycle |
| err_flag | output | 1 | Sticky illegal-state flag |

## Verification
A table-driven frame uses a two-byte payload with a slave response. It mixes stalled cycles with strobes, and it sends start requests and a new length in the middle of the frame. This shows that each phase waits for its strobe and that the settings were latched rather than read live. Two further frames, one with a single byte and no response and one with the full eight bytes, separate the off-by-one cases of the byte counter and the two paths out of the checksum phase. The injection tests cover an upset that leaves no bit set (in idle) and one that leaves two bits set (mid-frame). They also cover a clear that arrives in the same cycle as a new detection, which tests the priority rule of the sticky flag.

// File: rtl/lin_fseq_pkg.sv
package lin_fseq_pkg;
  localparam int unsigned NSTATE = 8;
  localparam int unsigned SEL_W  = $clog2(NSTATE);

  // bit index of each phase in the one-hot vector
  localparam int unsigned B_IDLE = 0;
  localparam int unsigned B_BRK  = 1;
  localparam int unsigned B_SYN  = 2;
  localparam int unsigned B_PID  = 3;
  localparam int unsigned B_DAT  = 4;
  localparam int unsigned B_CKS  = 5;
  localparam int unsigned B_RSP  = 6;
  localparam int unsigned B_DON  = 7;

  typedef logic [NSTATE-1:0] svec_t;

  localparam svec_t IDLE_VEC = svec_t'(1) << B_IDLE;
endpackage

// File: rtl/lin_fseq_count.sv
module lin_fseq_count #(
  parameter int unsigned MAX_BYTES = 8,
  localparam int unsigned LEN_W = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_idle,
  input  logic             in_data,
  input  logic             start_req,
  input  logic             byte_done,
  input  logic [LEN_W-1:0] len_in,
  input  logic             dir_in,
  output logic             last_byte,
  output logic             dir_q
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (in_idle && start_req) begin
      len_q <= len_in;
      dir_q <= dir_in;
      cnt_q <= '0;
    end else if (in_data && byte_done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_byte = (cnt_q == len_q);
endmodule

// File: rtl/lin_fseq_next.sv
module lin_fseq_next
  import lin_fseq_pkg::*;
(
  input  svec_t cur,
  input  logic  start_req,
  input  logic  byte_done,
  input  logic  last_byte,
  input  logic  dir_q,
  output svec_t nxt
);
  always_comb begin
    nxt = '0;
    nxt[B_IDLE] = (cur[B_IDLE] & ~start_req) | cur[B_DON];
    nxt[B_BRK]  = (cur[B_IDLE] & start_req) | (cur[B_BRK] & ~byte_done);
    nxt[B_SYN]  = (cur[B_BRK] & byte_done) | (cur[B_SYN] & ~byte_done);
    nxt[B_PID]  = (cur[B_SYN] & byte_done) | (cur[B_PID] & ~byte_done);
    nxt[B_DAT]  = (cur[B_PID] & byte_done) | (cur[B_DAT] & ~(byte_done & last_byte));
    nxt[B_CKS]  = (cur[B_DAT] & byte_done & last_byte) | (cur[B_CKS] & ~byte_done);
    nxt[B_RSP]  = (cur[B_CKS] & byte_done & dir_q) | (cur[B_RSP] & ~byte_done);
    nxt[B_DON]  = (cur[B_CKS] & byte_done & ~dir_q) | (cur[B_RSP] & byte_done);
  end
endmodule

// File: rtl/lin_fseq_legal.sv
module lin_fseq_legal #(
  parameter int unsigned W = 8,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0] vec,
  output logic         illegal
);
  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(vec[i]);
    end
    illegal = (ones != CW'(1));
  end
endmodule

// File: rtl/lin_frame_seq.sv
module lin_frame_seq
  import lin_fseq_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_req,
  input  logic                         byte_done,
  input  logic [$clog2(MAX_BYTES)-1:0] data_len,
  input  logic                         resp_dir,
  input  logic                         err_clr,
  input  logic                         inj_en,
  input  logic [SEL_W-1:0]             inj_sel,
  output logic [NSTATE-1:0]            state_en,
  output logic                         frame_done,
  output logic                         err_flag
);
  svec_t st_q, st_nxt, st_d, inj_mask;
  logic  illegal, last_byte, dir_q;

  lin_fseq_count #(.MAX_BYTES(MAX_BYTES)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .in_idle   (st_q[B_IDLE]),
    .in_data   (st_q[B_DAT]),
    .start_req (start_req),
    .byte_done (byte_done),
    .len_in    (data_len),
    .dir_in    (resp_dir),
    .last_byte (last_byte),
    .dir_q     (dir_q)
  );

  lin_fseq_next u_next (
    .cur       (st_q),
    .start_req (start_req),
    .byte_done (byte_done),
    .last_byte (last_byte),
    .dir_q     (dir_q),
    .nxt       (st_nxt)
  );

  lin_fseq_legal #(.W(NSTATE)) u_legal (
    .vec     (st_q),
    .illegal (illegal)
  );

  assign inj_mask = inj_en ? (svec_t'(1) << inj_sel) : '0;
  assign st_d     = (illegal ? IDLE_VEC : st_nxt) ^ inj_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= IDLE_VEC;
      err_flag <= 1'b0;
    end else begin
      st_q <= st_d;
      if (illegal)      err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end

  assign state_en   = st_q;
  assign frame_done = st_q[B_DON];
endmodule

// File: rtl/lin_frame_seq_chk.sv
module lin_frame_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_req,
  input logic       byte_done,
  input logic       err_clr,
  input logic       inj_en,
  input logic [7:0] state_en,
  input logic       frame_done,
  input logic       err_flag
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (state_en == 8'h01 && !frame_done && !err_flag));

  p_start_break_r2: assert property (@(posedge clk) disable iff (rst)
    (state_en == 8'h01 && start_req && !inj_en) |=> (state_en == 8'h02));

  p_break_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state_en == 8'h02 && !byte_done && !inj_en) |=> (state_en == 8'h02));

  p_resp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_en == 8'h40 && !byte_done && !inj_en) |=> (state_en == 8'h40));

  p_done_once_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && $countones(state_en) == 1 && !inj_en)
      |=> (state_en == 8'h01 && !frame_done));

  p_stay_legal_r8: assert property (@(posedge clk) disable iff (rst)
    ($countones(state_en) == 1 && !inj_en) |=> ($countones(state_en) == 1));

  p_recover_r10: assert property (@(posedge clk) disable iff (rst)
    ($countones(state_en) != 1 && !inj_en) |=> (state_en == 8'h01 && err_flag));

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);
endmodule

bind lin_frame_seq lin_frame_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_req  (start_req),
  .byte_done  (byte_done),
  .err_clr    (err_clr),
  .inj_en     (inj_en),
  .state_en   (state_en),
  .frame_done (frame_done),
  .err_flag   (err_flag)
);

// File: tb/lin_frame_seq_test.sv
module lin_frame_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 1'b0;
  logic       byte_done = 1'b0;
  logic [2:0] data_len = 3'd0;
  logic       resp_dir = 1'b0;
  logic       err_clr = 1'b0;
  logic       inj_en = 1'b0;
  logic [2:0] inj_sel = 3'd0;
  logic [7:0] state_en;
  logic       frame_done;
  logic       err_flag;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  lin_frame_seq #(.MAX_BYTES(8)) uut (
    .clk(clk), .rst(rst), .start_req(start_req), .byte_done(byte_done),
    .data_len(data_len), .resp_dir(resp_dir), .err_clr(err_clr),
    .inj_en(inj_en), .inj_sel(inj_sel), .state_en(state_en),
    .frame_done(frame_done), .err_flag(err_flag)
  );

  // {start, byte_done, expected state_en[7:0], expected frame_done}
  // frame: 2 data bytes (len field 1), slave response expected
  localparam logic [10:0] VEC [14] = '{
    {1'b0, 1'b1, 8'h01, 1'b0},  // R2 strobe ignored in idle
    {1'b1, 1'b0, 8'h02, 1'b0},  // R2 start -> break
    {1'b1, 1'b0, 8'h02, 1'b0},  // R12 start ignored, R3 hold
    {1'b0, 1'b1, 8'h04, 1'b0},  // R3 -> sync
    {1'b0, 1'b0, 8'h04, 1'b0},  // R3 hold
    {1'b0, 1'b1, 8'h08, 1'b0},  // R3 -> identifier
    {1'b0, 1'b1, 8'h10, 1'b0},  // R3 -> data
    {1'b1, 1'b1, 8'h10, 1'b0},  // R4 first byte, R12
    {1'b0, 1'b0, 8'h10, 1'b0},  // R4 hold
    {1'b0, 1'b1, 8'h20, 1'b0},  // R4 second byte -> checksum
    {1'b0, 1'b1, 8'h40, 1'b0},  // R5 response wait
    {1'b0, 1'b0, 8'h40, 1'b0},  // R6 hold
    {1'b0, 1'b1, 8'h80, 1'b1},  // R6 -> done, R7 strobe
    {1'b0, 1'b0, 8'h01, 1'b0}   // R7 back to idle
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // apply inputs, take one edge, leave sample point 1 ns after the edge
  task automatic cyc(input logic s, input logic bd);
    start_req = s;
    byte_done = bd;
    @(posedge clk);
    #1;
    start_req = 1'b0;
    byte_done = 1'b0;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    // R1 reset
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    chk("R1 state", 32'(state_en), 32'h01);
    chk("R1 done", 32'(frame_done), 32'h0);
    chk("R1 err", 32'(err_flag), 32'h0);

    // table-driven frame
    data_len = 3'd1;
    resp_dir = 1'b1;
    for (int i = 0; i < 14; i++) begin
      if (i == 2) begin
        data_len = 3'd7;   // R4 mid-frame change must not matter
        resp_dir = 1'b0;   // R5 latched value stays 1
      end
      cyc(VEC[i][10], VEC[i][9]);
      chk($sformatf("R2-R7 vec%0d state", i), 32'(state_en), 32'(VEC[i][8:1]));
      chk($sformatf("R7 vec%0d done", i), 32'(frame_done), 32'(VEC[i][0]));
      chk("R8 onehot", 32'($countones(state_en)), 32'd1);
    end

    // R4 single byte, R5 no response
    data_len = 3'd0;
    resp_dir = 1'b0;
    cyc(1, 0);
    cyc(0, 1); cyc(0, 1); cyc(0, 1);
    chk("R4 len1 in data", 32'(state_en), 32'h10);
    cyc(0, 1);
    chk("R4 len1 checksum", 32'(state_en), 32'h20);
    cyc(0, 1);
    chk("R5 no response -> done", 32'(state_en), 32'h80);
    chk("R7 done strobe", 32'(frame_done), 32'h1);
    cyc(0, 0);
    chk("R7 idle", 32'(state_en), 32'h01);

    // R4 eight bytes
    data_len = 3'd7;
    cyc(1, 0);
    cyc(0, 1); cyc(0, 1); cyc(0, 1);
    for (int k = 0; k < 7; k++) cyc(0, 1);
    chk("R4 len8 after 7 bytes", 32'(state_en), 32'h10);
    cyc(0, 1);
    chk("R4 len8 after 8 bytes", 32'(state_en), 32'h20);
    cyc(0, 1);
    cyc(0, 0);
    chk("R7 idle after len8", 32'(state_en), 32'h01);

    // R9 R10 zero-hot upset in idle
    inj_en = 1'b1; inj_sel = 3'd0;
    cyc(0, 0);
    inj_en = 1'b0;
    chk("R9 zero-hot", 32'(state_en), 32'h00);
    chk("R10 err not yet", 32'(err_flag), 32'h0);
    cyc(0, 0);
    chk("R10 recovered", 32'(state_en), 32'h01);
    chk("R10 err set", 32'(err_flag), 32'h1);
    cyc(1, 0); cyc(0, 1); cyc(0, 0);
    chk("R11 sticky", 32'(err_flag), 32'h1);
    err_clr = 1'b1;
    cyc(0, 0);
    err_clr = 1'b0;
    chk("R11 cleared", 32'(err_flag), 32'h0);
    chk("R11 frame kept going", 32'(state_en), 32'h04);

    // R9 R10 two-hot upset in sync, then clear colliding with detection
    inj_en = 1'b1; inj_sel = 3'd5;
    cyc(0, 0);
    inj_en = 1'b0;
    chk("R9 two-hot", 32'(state_en), 32'h24);
    err_clr = 1'b1;
    cyc(0, 1);
    err_clr = 1'b0;
    chk("R10 two-hot recovered", 32'(state_en), 32'h01);
    chk("R11 set beats clear", 32'(err_flag), 32'h1);
    chk("R10 no done strobe", 32'(frame_done), 32'h0);

    summary();
  end
endmodule